// File: doc/BRIEF.md
# Peripheral Bus Transfer Sequencer

This block is the master side of a bridge onto a low-bandwidth peripheral bus. A command port carries one request at a time: an address, a write flag and write data, with a valid input and a ready output. The block takes a request in on the cycle both are high. It then runs the request through a setup phase and an access phase on the bus and reports the result with a one-cycle completion strobe. Read data is returned on that same strobe.

A small fixed decoder maps the top bits of the address to one of several peripheral select lines. If a new request waits on the command port during the access phase, the block goes straight into the setup phase of that request. No idle cycle is inserted between the two transfers.

Top module: `pbus_sequencer`

## Requirements
- R1: After synchronous reset, all select lines and the enable line are low, the done strobe is low, and the command port's ready output is high.
- R2: The ready output is high only in the idle phase and in the access (enable) phase, and low in the setup phase. A request is taken on a rising edge at which both valid and ready are high.
- R3: In the cycle after a request is taken, the block is in the setup phase for exactly one cycle. Exactly one select line is high: select bit k, where k is the value of address bits [ADDR_W-1:ADDR_W-2]. The enable line is low.
- R4: The cycle after setup is always the access phase, and it lasts exactly one cycle. The enable line is high. Address, write flag and select lines keep the values they had in setup.
- R5: In the cycle after the access phase, done is high for exactly one cycle. For a read, the read-data output holds the bus read data sampled at the end of the access phase.
- R6: Write data is driven from the setup phase through the access phase. A write transfer leaves the read-data output unchanged.
- R7: If no request is taken during the access phase, the next cycle is idle: all selects and enable are low.
- R8: A request taken during the access phase starts its setup phase on the very next cycle. That is the same cycle as the previous transfer's done strobe, and the address and select may change at that point.
- R9: A request presented during the setup phase is not taken. The bus address stays that of the running transfer through the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Request acknowledge (taken when valid and ready) |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Request write data |
| done | output | 1 | One-cycle completion strobe |
| rdata_out | output | DATA_W | Read data of the last completed read |
| bus_sel | output | NUM_SEL | One-hot peripheral select lines |
| bus_enable | output | 1 | Access-phase enable |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Read data returned by the selected peripheral |

## Verification
Two events can fall in the same cycle: the done strobe of one transfer and the setup phase of the next. To provoke this, the bench holds a second request on the command port during the access phase of the first. In the cycle that follows, it checks that done is high and the first read's data is on the output. In that same cycle the select line of the second target is high with enable low. The bench also raises a request during setup and confirms that it waits, and that the running address is unchanged.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ENABLE = 2'd2
    } phase_e;

    // Phases in which the command port may hand over a new request
    function automatic logic phase_takes_request(phase_e p);
        return (p == PH_IDLE) || (p == PH_ENABLE);
    endfunction

    function automatic phase_e phase_next(phase_e p, logic take);
        phase_e n;
        case (p)
            PH_IDLE:   n = take ? PH_SETUP : PH_IDLE;
            PH_SETUP:  n = PH_ENABLE;
            PH_ENABLE: n = take ? PH_SETUP : PH_IDLE;
            default:   n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pbs_phase_ctrl.sv
module pbs_phase_ctrl
    import pbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   req_ready,
    output logic   take,
    output phase_e phase
);

    phase_e phase_q;

    assign req_ready = phase_takes_request(phase_q);
    assign take      = req_valid && req_ready;
    assign phase     = phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_next(phase_q, take);
    end

    // R3 / R4: setup lasts one cycle and is always followed by access
    a_r3_setup_then_enable: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_SETUP |=> phase_q == PH_ENABLE);

    // R7: access without a new request returns to idle
    a_r7_enable_to_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ENABLE && !req_valid) |=> phase_q == PH_IDLE);

endmodule

// File: rtl/pbs_cmd_reg.sv
module pbs_cmd_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic [DATA_W-1:0] cur_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
        end else if (take) begin
            cur_addr  <= in_addr;
            cur_write <= in_write;
            cur_wdata <= in_wdata;
        end
    end

endmodule

// File: rtl/pbs_sel_decode.sv
module pbs_sel_decode #(
    parameter int ADDR_W  = 16,
    parameter int NUM_SEL = 4
) (
    input  logic               active,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] sel
);

    localparam int SEL_BITS = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;

    logic [SEL_BITS-1:0] region;
    assign region = addr[ADDR_W-1 -: SEL_BITS];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel[i] = active && (region == SEL_BITS'(i));
    end

endmodule

// File: rtl/pbs_resp_capture.sv
module pbs_resp_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_access,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            rdata_out <= '0;
        end else begin
            done <= in_access;
            if (in_access && !is_write) rdata_out <= bus_rdata;
        end
    end

    // R6: a completed write leaves the read data untouched
    a_r6_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
        (in_access && is_write) |=> $stable(rdata_out));

endmodule

// File: rtl/pbus_sequencer.sv
module pbus_sequencer
    import pbs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NUM_SEL = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               done,
    output logic [DATA_W-1:0]  rdata_out,
    output logic [NUM_SEL-1:0] bus_sel,
    output logic               bus_enable,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_write,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata
);

    phase_e phase;
    logic   take;
    logic   busy;
    logic   access;

    pbs_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .take      (take),
        .phase     (phase)
    );

    pbs_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .in_addr   (req_addr),
        .in_write  (req_write),
        .in_wdata  (req_wdata),
        .cur_addr  (bus_addr),
        .cur_write (bus_write),
        .cur_wdata (bus_wdata)
    );

    assign busy   = (phase != PH_IDLE);
    assign access = (phase == PH_ENABLE);
    assign bus_enable = access;

    pbs_sel_decode #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)) u_dec (
        .active (busy),
        .addr   (bus_addr),
        .sel    (bus_sel)
    );

    pbs_resp_capture #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_access (access),
        .is_write  (bus_write),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rdata_out (rdata_out)
    );

    // R3: never more than one select line
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sel));

    // R1 / R7: enable only with a select line high
    a_r7_enable_needs_sel: assert property (@(posedge clk) disable iff (rst)
        bus_enable |-> (bus_sel != '0));

    // R4: controls hold from setup into access
    a_r4_stable_into_access: assert property (@(posedge clk) disable iff (rst)
        ((bus_sel != '0) && !bus_enable) |=>
            (bus_enable && $stable(bus_addr) && $stable(bus_sel) && $stable(bus_write)));

    // R5: one completion strobe for each access cycle
    a_r5_done_after_access: assert property (@(posedge clk) disable iff (rst)
        bus_enable |=> done);

    // R2: no acknowledge during setup
    a_r2_no_ready_in_setup: assert property (@(posedge clk) disable iff (rst)
        ((bus_sel != '0) && !bus_enable) |-> !req_ready);

endmodule

// File: tb/test_pbus_sequencer.sv
module test_pbus_sequencer;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int NUM_SEL = 4;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr;
    logic               req_write;
    logic [DATA_W-1:0]  req_wdata;
    logic               done;
    logic [DATA_W-1:0]  rdata_out;
    logic [NUM_SEL-1:0] bus_sel;
    logic               bus_enable;
    logic [ADDR_W-1:0]  bus_addr;
    logic               bus_write;
    logic [DATA_W-1:0]  bus_wdata;
    logic [DATA_W-1:0]  bus_rdata;

    int errors = 0;
    int checks = 0;
    logic [DATA_W-1:0] exp_rd = '0;

    always #5 clk = ~clk;

    pbus_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) i_pbus_sequencer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .rdata_out(rdata_out),
        .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NUM_SEL-1:0] sel_for(logic [ADDR_W-1:0] a);
        return NUM_SEL'(1) << a[ADDR_W-1 -: 2];
    endfunction

    // Present a request in the current (idle) cycle
    task automatic present(logic [ADDR_W-1:0] a, logic w, logic [DATA_W-1:0] d);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "sel", 64'(bus_sel), 64'(0));
        check("R1", "enable", 64'(bus_enable), 64'(0));
        check("R1", "done", 64'(done), 64'(0));
        check("R1", "ready", 64'(req_ready), 64'(1));
        exp_rd = '0;
    endtask

    // One transfer from idle back to idle
    task automatic test_single(logic [ADDR_W-1:0] a, logic w, logic [DATA_W-1:0] d,
                               logic [DATA_W-1:0] rd);
        present(a, w, d);
        #1 check("R2", "ready idle", 64'(req_ready), 64'(1));
        @(negedge clk);
        req_valid = 1'b0;
        bus_rdata = rd;
        check("R3", "setup sel", 64'(bus_sel), 64'(sel_for(a)));
        check("R3", "setup enable", 64'(bus_enable), 64'(0));
        check("R2", "ready setup", 64'(req_ready), 64'(0));
        check("R6", "setup wdata", 64'(bus_wdata), 64'(d));
        @(negedge clk);
        check("R4", "access enable", 64'(bus_enable), 64'(1));
        check("R4", "access sel", 64'(bus_sel), 64'(sel_for(a)));
        check("R4", "access addr", 64'(bus_addr), 64'(a));
        check("R4", "access write", 64'(bus_write), 64'(w));
        check("R6", "access wdata", 64'(bus_wdata), 64'(d));
        bus_rdata = rd;
        @(negedge clk);
        if (!w) exp_rd = rd;
        check("R5", "done", 64'(done), 64'(1));
        check(w ? "R6" : "R5", "rdata", 64'(rdata_out), 64'(exp_rd));
        check("R7", "idle sel", 64'(bus_sel), 64'(0));
        check("R7", "idle enable", 64'(bus_enable), 64'(0));
        @(negedge clk);
        check("R5", "done one cycle", 64'(done), 64'(0));
    endtask

    // Second request held from setup of the first: waits, then follows directly
    task automatic test_back_to_back();
        logic [ADDR_W-1:0] a1 = 16'h4010;
        logic [ADDR_W-1:0] a2 = 16'hC020;
        present(a1, 1'b0, '0);
        @(negedge clk);
        present(a2, 1'b1, 32'hCAFE_0001);
        check("R9", "ready in setup", 64'(req_ready), 64'(0));
        bus_rdata = 32'h1234_5678;
        @(negedge clk);
        check("R9", "addr kept", 64'(bus_addr), 64'(a1));
        check("R9", "sel kept", 64'(bus_sel), 64'(sel_for(a1)));
        check("R2", "ready in access", 64'(req_ready), 64'(1));
        @(negedge clk);
        req_valid = 1'b0;
        exp_rd = 32'h1234_5678;
        check("R8", "done with next setup", 64'(done), 64'(1));
        check("R8", "rdata first", 64'(rdata_out), 64'(exp_rd));
        check("R8", "next sel", 64'(bus_sel), 64'(sel_for(a2)));
        check("R8", "next enable low", 64'(bus_enable), 64'(0));
        check("R8", "next addr", 64'(bus_addr), 64'(a2));
        bus_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R8", "second access", 64'(bus_enable), 64'(1));
        check("R8", "done low", 64'(done), 64'(0));
        @(negedge clk);
        check("R8", "second done", 64'(done), 64'(1));
        check("R6", "rdata after write", 64'(rdata_out), 64'(exp_rd));
        check("R7", "idle after", 64'(bus_sel), 64'(0));
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_single(16'h0004, 1'b0, '0, 32'hA5A5_0001);
        test_single(16'hC0F0, 1'b0, '0, 32'h0BAD_F00D);
        test_single(16'h8100, 1'b1, 32'h7777_1111, 32'hFFFF_FFFF);
        test_single(16'h4000, 1'b0, '0, 32'h0000_0042);
        test_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule